// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit timer channel with a clock divider, four general registers and two pins that can each be an input or an output. The counter runs from the core clock divided by 1, 4, 16, 64, 256 or 1024. Each general register either compares against the counter or captures the counter on an edge of its pin. On a compare match, a pin can be driven low, driven high or toggled. Any general register can be picked to zero the counter, either when it matches or when it captures.

Registers A and B are the primary registers. Register C can be made a shadow of A, and register D a shadow of B. In compare mode the shadow supplies the next compare value when its primary matches. In capture mode the shadow keeps the value its primary held before each new capture.

A shared clear input zeroes the counter on the same clock in every channel that receives it, so several channels can run in lockstep. Software reaches the channel through a plain write port and a combinational read port.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset, the registers read as follows: COUNT, CTRL and STATUS are 0, every general register is 0xFFFF, both pins output 0, and both pin enables are 1.
- R2: While CTRL bit 3 (run) is set, the counter advances by one once every 4^sel clock cycles, where sel is CTRL[2:0]. Values 6 and 7 act as 5. While run is clear, the counter holds its value.
- R3: A compare match occurs on a counter step when the counter equals a general register that is in compare mode. The match sets that register's status flag. For A (pin 0) and B (pin 1) the match also applies the register's mode bits [1:0] to the pin: 0 leaves it, 1 drives 0, 2 drives 1, 3 toggles. Without a match, the pin level stays unchanged.
- R4: A register whose mode bit 3 is set is in capture mode. Its pin passes through a two-flop synchroniser. Mode bits [1:0] choose the edge: 1 is rising, 2 is falling, 3 is both. On a chosen edge the register loads the counter and sets its status flag. A and C use pin 0; B and D use pin 1.
- R5: CTRL[6:4] picks the clear source: 0 is none, and 1 to 4 select A to D. A match of the source sets the counter to 0 in place of the increment. A capture of the source sets the counter to 0 at once.
- R6: CTRL bit 7 links C to A, and bit 8 links D to B. With a link set and the primary in compare mode, a match of the primary loads the primary from its shadow. A shadow register never raises events of its own.
- R7: With a link set and the primary in capture mode, each capture moves the primary's old value into its shadow while the primary takes the counter.
- R8: A counter step from 0xFFFF to 0 sets STATUS bit 4 (overflow).
- R9: STATUS bits 3:0 are the flags of A to D. Writing 1 to a STATUS bit clears it, and writing 0 leaves it. If a new event and a clear land on the same cycle, the event wins.
- R10: The sync_clr input zeroes the counter on the next clock. It takes priority over a software write and over counting.
- R11: Each pin's output enable is 1 when its primary register is in compare mode and 0 when it is in capture mode.
- R12: The address map is 0 CTRL (9 bits), 1 MODE (4 bits per register, with A in the low nibble), 2 STATUS, 3 COUNT, and 4 to 7 for general registers A to D. Written values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write address |
| wr_data | input | 16 | write data |
| rd_addr | input | 3 | read address |
| rd_data | output | 16 | read data (combinational) |
| sync_clr | input | 1 | shared counter clear |
| pin_in | input | 2 | pin levels seen from outside |
| pin_out | output | 2 | pin drive levels |
| pin_oe | output | 2 | pin output enables |

## Verification
A divider that is wrong shows up as a COUNT that is off after a run of known length. This is visible as soon as the run ends, because the step count is exactly floor(cycles / 4^sel). A wrong match or a missed clear decision shows up in one cycle, as a pin level or a COUNT residue modulo the compare period. A synchroniser or edge-select fault either leaves a register unchanged or loads it with the wrong value within four cycles of the pin change. A broken shadow link leaves A and C with swapped or stale values that can be read back directly.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int AW      = 3;
  localparam int SEL_W   = 3;
  localparam int MAX_SEL = 5;
  localparam int PRE_W   = 2 * MAX_SEL;

  localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADDR_MODE = 3'd1;
  localparam logic [AW-1:0] ADDR_STAT = 3'd2;
  localparam logic [AW-1:0] ADDR_CNT  = 3'd3;
  localparam logic [AW-1:0] ADDR_GR0  = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_FLIP = 2'd3
  } pin_act_e;

  // low bits of the divider that must all be set for a step
  function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] s;
    logic [PRE_W:0]   one;
    s   = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
    one = (PRE_W+1)'(1) << (2 * s);
    return one[PRE_W-1:0] - PRE_W'(1);
  endfunction

  function automatic logic edge_hit(input logic [1:0] esel, input logic rise, input logic fall);
    return (esel[0] & rise) | (esel[1] & fall);
  endfunction

  function automatic logic apply_act(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = pre_mask(sel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cct_edge_det.sv
module cct_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // [0],[1] synchroniser, [2] previous synchronised level
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], din};
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cct_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NGR  = 4,
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data,
  input  logic            sync_clr,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  localparam int NPRI = NGR / 2;
  localparam int GIW  = $clog2(NGR);

  logic [SEL_W-1:0]      sel_q;
  logic                  run_q;
  logic [2:0]            clr_src_q;
  logic [NPRI-1:0]       buf_q;
  logic [NGR-1:0][3:0]   mode_q;
  logic [CW-1:0]         gr_q [NGR];
  logic [NGR-1:0]        flag_q;
  logic                  ovf_q;
  logic [CW-1:0]         cnt_q;
  logic [NPIN-1:0]       pout_q;

  logic                  tick;
  logic [NPIN-1:0]       rise_w, fall_w;
  logic [NGR-1:0]        match_ev, cap_ev, is_buf, wr_gr;
  logic                  wr_ctrl, wr_mode, wr_stat, wr_cnt;
  logic                  clr_by_match, clr_by_cap, ovf_set;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_mode = wr_en && (wr_addr == ADDR_MODE);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);

  cct_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(sel_q), .tick(tick)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    cct_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .din(pin_in[p]), .rise(rise_w[p]), .fall(fall_w[p])
    );
    assign pin_oe[p] = ~mode_q[p][3];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pout_q[p] <= 1'b0;
      else if (match_ev[p]) pout_q[p] <= apply_act(mode_q[p][1:0], pout_q[p]);
    end
  end
  assign pin_out = pout_q;

  // per-register events
  for (genvar k = 0; k < NGR; k++) begin : g_evt
    localparam int PI = k % NPIN;
    if (k >= NPRI) begin : g_shadow
      assign is_buf[k] = buf_q[k-NPRI];
    end else begin : g_primary
      assign is_buf[k] = 1'b0;
    end
    assign wr_gr[k]    = wr_en && (wr_addr == ADDR_GR0 + AW'(k));
    assign match_ev[k] = tick && !mode_q[k][3] && !is_buf[k] && (cnt_q == gr_q[k]);
    assign cap_ev[k]   = mode_q[k][3] && !is_buf[k] &&
                         edge_hit(mode_q[k][1:0], rise_w[PI], fall_w[PI]);
  end

  // general registers, shadow links by position
  for (genvar k = 0; k < NGR; k++) begin : g_gr
    if (k < NPRI) begin : g_pri
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         gr_q[k] <= '1;
        else if (cap_ev[k])                 gr_q[k] <= cnt_q;
        else if (buf_q[k] && match_ev[k])   gr_q[k] <= gr_q[k+NPRI];
        else if (wr_gr[k])                  gr_q[k] <= wr_data;
      end
    end else begin : g_sec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            gr_q[k] <= '1;
        else if (cap_ev[k])                    gr_q[k] <= cnt_q;
        else if (is_buf[k] && cap_ev[k-NPRI])  gr_q[k] <= gr_q[k-NPRI];
        else if (wr_gr[k])                     gr_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    clr_by_match = 1'b0;
    clr_by_cap   = 1'b0;
    for (int k = 0; k < NGR; k++) begin
      if (clr_src_q == 3'(k + 1)) begin
        clr_by_match = match_ev[k];
        clr_by_cap   = cap_ev[k];
      end
    end
  end

  assign ovf_set = tick && (cnt_q == '1) && !clr_by_match && !clr_by_cap && !sync_clr && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (sync_clr)   cnt_q <= '0;
    else if (wr_cnt)     cnt_q <= wr_data;
    else if (clr_by_cap) cnt_q <= '0;
    else if (tick)       cnt_q <= clr_by_match ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; run_q <= 1'b0; clr_src_q <= '0; buf_q <= '0; mode_q <= '0;
      flag_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q     <= wr_data[2:0];
        run_q     <= wr_data[3];
        clr_src_q <= wr_data[6:4];
        buf_q     <= wr_data[7 +: NPRI];
      end
      if (wr_mode) mode_q <= wr_data[4*NGR-1:0];
      flag_q <= (flag_q & ~(wr_stat ? wr_data[NGR-1:0] : '0)) | match_ev | cap_ev;
      ovf_q  <= (ovf_q & ~(wr_stat & wr_data[NGR])) | ovf_set;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = CW'({buf_q, clr_src_q, run_q, sel_q});
      ADDR_MODE: rd_data = CW'(mode_q);
      ADDR_STAT: rd_data = CW'({ovf_q, flag_q});
      ADDR_CNT:  rd_data = cnt_q;
      default:   rd_data = gr_q[rd_addr[GIW-1:0]];
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_clr,
  input logic          tick,
  input logic          wr_cnt,
  input logic          clr_by_match,
  input logic          clr_by_cap,
  input logic [CW-1:0] cnt,
  input logic          ovf,
  input logic          cap_a,
  input logic          match_a,
  input logic [CW-1:0] gr_a,
  input logic          pin_a
);
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (cnt == '0)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_clr && !wr_cnt && !clr_by_cap) |=> $stable(cnt)); // R2
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_clr && !wr_cnt && !clr_by_cap && !clr_by_match) |=> (cnt == CW'($past(cnt) + 1'b1))); // R2
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_by_match && !sync_clr && !wr_cnt) |=> (cnt == '0)); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == '1) && !clr_by_match && !clr_by_cap && !sync_clr && !wr_cnt) |=> ovf); // R8
  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> (gr_a == $past(cnt))); // R4
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !match_a |=> $stable(pin_a)); // R3
endmodule

bind cc_timer_chan cct_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .tick(tick), .wr_cnt(wr_cnt),
  .clr_by_match(clr_by_match), .clr_by_cap(clr_by_cap), .cnt(cnt_q), .ovf(ovf_q),
  .cap_a(cap_ev[0]), .match_a(match_ev[0]), .gr_a(gr_q[0]), .pin_a(pout_q[0])
);

// File: tb/cc_timer_chan_test.sv
module cc_timer_chan_test;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_STAT = 3'd2, A_CNT = 3'd3;
  localparam logic [2:0] A_GRA = 3'd4, A_GRB = 3'd5, A_GRC = 3'd6, A_GRD = 3'd7;

  // prescaler vectors: {sel, counting cycles, expected COUNT}
  localparam int NVEC = 7;
  localparam int VEC [NVEC][3] = '{
    '{0, 40, 40}, '{1, 40, 10}, '{2, 64, 4}, '{3, 200, 3},
    '{4, 600, 2}, '{5, 2100, 2}, '{7, 1024, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sync_clr = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [1:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sync_clr(sync_clr),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    pin_in = '0; sync_clr = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // counts for exactly n clock edges
  task automatic run_for(input int n, input logic [15:0] ctrl);
    wr(A_CTRL, ctrl | 16'h0008);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, ctrl);
  endtask

  task automatic set_pin(input int p, input logic v);
    pin_in[p] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(A_CNT, 16'h0000, "R1 count");
    rd(A_CTRL, 16'h0000, "R1 ctrl");
    rd(A_STAT, 16'h0000, "R1 status");
    rd(A_GRA, 16'hFFFF, "R1 gr A");
    rd(A_GRD, 16'hFFFF, "R1 gr D");
    check("R1 pin_out", {14'd0, pin_out}, 16'h0000);
    check("R1 pin_oe", {14'd0, pin_oe}, 16'h0003);

    // R2 prescaler vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CNT, 16'h0000);
      run_for(VEC[i][1], 16'(VEC[i][0]));
      rd(A_CNT, 16'(VEC[i][2]), "R2 divide");
    end
    repeat (10) @(negedge clk);
    rd(A_CNT, 16'h0001, "R2 hold while stopped");

    // R12 read-back
    wr(A_CTRL, 16'h0175);
    rd(A_CTRL, 16'h0175, "R12 ctrl");
    wr(A_MODE, 16'h1234);
    rd(A_MODE, 16'h1234, "R12 mode");
    wr(A_GRD, 16'hBEEF);
    rd(A_GRD, 16'hBEEF, "R12 gr D");

    // R3 compare actions on pin 0
    do_reset();
    wr(A_MODE, 16'h0002);
    wr(A_GRA, 16'h0005);
    run_for(10, 16'h0000);
    check("R3 drive high", {15'd0, pin_out[0]}, 16'h0001);
    rd(A_STAT, 16'h0001, "R3 flag A");
    rd(A_CNT, 16'h000A, "R3 count passes match");
    wr(A_MODE, 16'h0001);
    wr(A_CNT, 16'h0000);
    run_for(10, 16'h0000);
    check("R3 drive low", {15'd0, pin_out[0]}, 16'h0000);
    wr(A_MODE, 16'h0003);
    wr(A_CNT, 16'h0000);
    run_for(10, 16'h0000);
    check("R3 toggle", {15'd0, pin_out[0]}, 16'h0001);
    wr(A_MODE, 16'h0000);
    wr(A_CNT, 16'h0000);
    run_for(10, 16'h0000);
    check("R3 keep", {15'd0, pin_out[0]}, 16'h0001);

    // R11 pin direction
    wr(A_MODE, 16'h0092);
    check("R11 oe A cmp B cap", {14'd0, pin_oe}, 16'h0001);

    // R5 clear on match: period 6
    do_reset();
    wr(A_GRA, 16'h0005);
    run_for(20, 16'h0010);
    rd(A_CNT, 16'h0002, "R5 clear on match");

    // R8 overflow, R9 write-1-to-clear
    do_reset();
    wr(A_CNT, 16'hFFFD);
    run_for(5, 16'h0000);
    rd(A_CNT, 16'h0002, "R8 wrap");
    rd(A_STAT, 16'h001F, "R8 overflow and matches");
    wr(A_STAT, 16'h0010);
    rd(A_STAT, 16'h000F, "R9 clear only overflow");
    wr(A_STAT, 16'h000F);
    rd(A_STAT, 16'h0000, "R9 clear flags");

    // R4 capture edges
    do_reset();
    wr(A_MODE, 16'h0009);
    wr(A_CNT, 16'h1234);
    set_pin(0, 1'b1);
    rd(A_GRA, 16'h1234, "R4 rising capture");
    rd(A_STAT, 16'h0001, "R4 flag A");
    check("R11 oe capture", {15'd0, pin_oe[0]}, 16'h0000);
    wr(A_MODE, 16'h00A0);
    wr(A_CNT, 16'h0AAA);
    set_pin(1, 1'b1);
    rd(A_GRB, 16'hFFFF, "R4 falling ignores rise");
    set_pin(1, 1'b0);
    rd(A_GRB, 16'h0AAA, "R4 falling capture");
    wr(A_MODE, 16'h000B);
    wr(A_CNT, 16'h0333);
    set_pin(0, 1'b0);
    rd(A_GRA, 16'h0333, "R4 both: fall");
    wr(A_CNT, 16'h0444);
    set_pin(0, 1'b1);
    rd(A_GRA, 16'h0444, "R4 both: rise");

    // R5 clear on capture
    do_reset();
    wr(A_MODE, 16'h0009);
    wr(A_CTRL, 16'h0010);
    wr(A_CNT, 16'h0050);
    set_pin(0, 1'b1);
    rd(A_GRA, 16'h0050, "R5 capture value");
    rd(A_CNT, 16'h0000, "R5 clear on capture");

    // R7 capture shadow
    do_reset();
    wr(A_CTRL, 16'h0080);
    wr(A_MODE, 16'h0009);
    wr(A_CNT, 16'h1111);
    set_pin(0, 1'b1);
    wr(A_CNT, 16'h2222);
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    rd(A_GRA, 16'h2222, "R7 primary new");
    rd(A_GRC, 16'h1111, "R7 shadow old");

    // R6 compare shadow
    do_reset();
    wr(A_MODE, 16'h0003);
    wr(A_GRA, 16'h0003);
    wr(A_GRC, 16'h0009);
    run_for(5, 16'h0080);
    rd(A_GRA, 16'h0009, "R6 reload from shadow");
    check("R6 pin toggled", {15'd0, pin_out[0]}, 16'h0001);
    rd(A_STAT, 16'h0001, "R6 shadow raises no flag");

    // R10 shared clear
    do_reset();
    wr(A_CNT, 16'h0077);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    rd(A_CNT, 16'h0000, "R10 sync clear");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule